// File: doc/BRIEF.md
# ADC conversion control unit

This block runs one analog-to-digital conversion at a time on behalf of an 8-bit processor. Software writes a control register holding a channel number, a start bit, an interrupt enable and a completion flag. It also writes a prescaler register. When software sets the start bit, the block steps a 10-bit successive-approximation search. At each step it drives a trial code to an external DAC and reads one comparator bit. The external analog multiplexer is steered to the chosen channel for the whole conversion.

The step rate comes from a clock enable derived from the processor clock. A prescaler value of zero gives a fixed divide-by-64. Any other value N gives a divide by 2·N. When the last bit is decided, the 10-bit result is loaded into two readable data registers and the completion flag is set. The start bit drops at the same moment. The flag stays set until software clears it. An interrupt line follows the flag while the interrupt enable is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing the control register (address 0) with bit 3 set while no conversion runs starts exactly one conversion. Bit 3 of the control register reads 1 while the conversion runs and reads 0 from the cycle its result is loaded.
- R2: The completion flag (control bit 4) becomes 1 in the same cycle the result registers take the new value. A control write with bit 4 = 0 clears the flag. A control write with bit 4 = 1 leaves the flag unchanged. If a clear and a completion coincide, the flag ends up set.
- R3: irq_o is 1 exactly while the completion flag and the interrupt enable (control bit 5) are both 1. After software clears the flag, the next completion raises irq_o again.
- R4: Control bits 2..0 select the analog input, with codes 0 to 7 giving inputs 0 to 7 on ch_sel_o. The code is taken when the conversion starts and stays on ch_sel_o until the conversion ends, even if software rewrites the field. The field itself reads back as last written.
- R5: The result is found in 10 steps from the MSB down to the LSB. A trial bit is kept when cmp_i = 1, meaning the input is at least the trial level. An input at or above full scale gives 0x3FF, an input at or below ground gives 0x000, and inputs in between give their linear code.
- R6: From the start write to the completion flag there are 10·D clock cycles. D is 64 when the prescaler register (address 1) is 0, and 2·value otherwise. The prescaler is taken when the conversion starts.
- R7: A start write during a running conversion is ignored: it neither restarts nor lengthens the conversion. The result registers keep their old value until completion.
- R8: Address 2 reads result bits 9..2. Address 3 reads result bits 1..0 in bits 1..0, with zeros above them. Address 1 reads the prescaler. Address 0 reads {2'b00, enable, flag, busy, channel}.
- R9: Reset clears every register, the completion flag, the running state and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| cmp_i | input | 1 | Comparator: 1 when the input is at least the DAC level |
| dac_code_o | output | 10 | Trial code to the DAC |
| ch_sel_o | output | 3 | Analog multiplexer select |
| irq_o | output | 1 | Interrupt request |

## Verification
The checks assume three things about the inputs. The comparator answer depends only on the selected channel and the current trial code. A write strobe lasts one cycle. The address is stable whenever a write is strobed. The bench meets these with a combinational comparator model: it compares a fixed per-channel level against dac_code_o. It changes all bus inputs only on the falling edge and holds each write for exactly one cycle. Channel levels are picked so that every channel gives a distinct code, including levels above full scale and below ground.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W   = 10;
    localparam int CH_W    = 3;
    localparam int PRS_W   = 8;
    localparam int DATA_W  = 8;
    localparam int DEF_DIV = 64;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_PRS  = 2'd1,
        A_RHI  = 2'd2,
        A_RLO  = 2'd3
    } reg_addr_t;

    typedef struct packed {
        logic             busy;
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] mask;
        logic [CH_W-1:0]  ch;
        logic [PRS_W-1:0] prs;
    } sar_state_t;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic             ien;
        logic             eoc;
        logic [PRS_W-1:0] prs;
        logic [RES_W-1:0] res;
    } ctl_regs_t;
endpackage

// File: rtl/adc_step_timer.sv
module adc_step_timer
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    localparam int CNT_W = PRS_W + 2;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        if (prs == '0) limit = CNT_W'(DEF_DIV - 1);
        else           limit = {1'b0, prs, 1'b0} - CNT_W'(1);
        tick  = en && (cnt_q == limit);
        cnt_d = (!en || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the divider never runs past its limit, so the latched prescaler is held
    a_r6_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt_q <= limit);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  start_ch,
    input  logic [PRS_W-1:0] start_prs,
    input  logic             tick,
    input  logic             cmp,
    output logic             busy,
    output logic [CH_W-1:0]  ch,
    output logic [PRS_W-1:0] prs,
    output logic [RES_W-1:0] trial,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam logic [RES_W-1:0] TOP_BIT = RES_W'(1) << (RES_W - 1);

    sar_state_t s_d, s_q;
    logic [RES_W-1:0] keep;

    always_comb begin
        s_d    = s_q;
        done   = 1'b0;
        keep   = cmp ? s_q.trial : (s_q.trial & ~s_q.mask);
        result = keep;
        if (!s_q.busy && start) begin
            s_d.busy  = 1'b1;
            s_d.ch    = start_ch;
            s_d.prs   = start_prs;
            s_d.mask  = TOP_BIT;
            s_d.trial = TOP_BIT;
        end else if (s_q.busy && tick) begin
            if (s_q.mask[0]) begin
                done      = 1'b1;
                s_d.busy  = 1'b0;
                s_d.trial = keep;
                s_d.mask  = '0;
            end else begin
                s_d.mask  = s_q.mask >> 1;
                s_d.trial = keep | (s_q.mask >> 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign ch    = s_q.ch;
    assign prs   = s_q.prs;
    assign trial = s_q.trial;

    // R4: the latched channel does not move while a conversion runs
    a_r4_ch_held: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (!s_q.busy || $stable(s_q.ch)));
    // R5: exactly one bit under trial at every step
    a_r5_one_step_bit: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> $countones(s_q.mask) == 1);
    // R7: a running conversion only ends through completion
    a_r7_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !done) |=> s_q.busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cmp_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic [CH_W-1:0]   ch_sel_o,
    output logic              irq_o
);
    localparam int LO_W = RES_W - DATA_W;

    ctl_regs_t r_d, r_q;
    logic start_req, tick, core_busy, core_done;
    logic [PRS_W-1:0] core_prs;
    logic [RES_W-1:0] core_result;

    always_comb begin
        r_d       = r_q;
        start_req = 1'b0;
        if (wr_en) begin
            case (reg_addr_t'(addr))
                A_CTRL: begin
                    r_d.ch  = wdata[CH_W-1:0];
                    r_d.ien = wdata[5];
                    if (!wdata[4]) r_d.eoc = 1'b0;
                    start_req = wdata[3] && !core_busy;
                end
                A_PRS:   r_d.prs = wdata[PRS_W-1:0];
                default: ;
            endcase
        end
        if (core_done) begin
            r_d.res = core_result;
            r_d.eoc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    adc_step_timer i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (core_busy),
        .prs   (core_prs),
        .tick  (tick)
    );

    adc_sar_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_req),
        .start_ch  (wdata[CH_W-1:0]),
        .start_prs (r_q.prs),
        .tick      (tick),
        .cmp       (cmp_i),
        .busy      (core_busy),
        .ch        (ch_sel_o),
        .prs       (core_prs),
        .trial     (dac_code_o),
        .done      (core_done),
        .result    (core_result)
    );

    always_comb begin
        case (reg_addr_t'(addr))
            A_CTRL:  rdata = {2'b00, r_q.ien, r_q.eoc, core_busy, r_q.ch};
            A_PRS:   rdata = r_q.prs;
            A_RHI:   rdata = r_q.res[RES_W-1:LO_W];
            default: rdata = {{(DATA_W-LO_W){1'b0}}, r_q.res[LO_W-1:0]};
        endcase
    end

    assign irq_o = r_q.eoc & r_q.ien;

    // R2: the flag holds unless software writes a clear
    a_r2_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.eoc && !(wr_en && addr == A_CTRL && !wdata[4])) |=> r_q.eoc);
    // R2: a completion always leaves the flag set
    a_r2_eoc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> r_q.eoc);
    // R7: the result registers change only on completion
    a_r7_result_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(r_q.res));
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int V_VIN [NV] = '{0, 1023, 2000, -50, 512, 341, 682, 1};
    localparam int V_EXP [NV] = '{0, 1023, 1023, 0, 512, 341, 682, 1};

    logic clk = 0, rst_n = 0, wr_en = 0, cmp_b;
    logic [1:0] addr_b = 0;
    logic [7:0] wdata = 0, rdata;
    logic [9:0] dac_code;
    logic [2:0] ch_sel;
    logic irq;
    int checks = 0, errors = 0, cyc = 0, t0 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always_comb cmp_b = (V_VIN[ch_sel] >= int'({22'b0, dac_code}));

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr_b), .wdata(wdata),
        .rdata(rdata), .cmp_i(cmp_b), .dac_code_o(dac_code), .ch_sel_o(ch_sel),
        .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr_b = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr_b = a; #1; v = int'(rdata);
    endtask

    task automatic start(input logic [7:0] ctrl);
        wr(2'd0, ctrl);
        t0 = cyc;
    endtask

    task automatic wait_eoc(output int dt);
        int v;
        dt = -1;
        for (int n = 0; n < 5000; n++) begin
            @(posedge clk); #1;
            rd(2'd0, v);
            if (v[4]) begin dt = cyc - t0; break; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL R6: watchdog expired, actual %0d expected 0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, dt;
        #(CLK_PERIOD * 2 + 3);
        rst_n = 1;
        // R9 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R9 register after reset", v, 0);
        end
        chk(irq == 0, "R9 irq after reset", int'(irq), 0);

        // R8 prescaler readback
        wr(2'd1, 8'd1);
        rd(2'd1, v);
        chk(v == 1, "R8 prescaler readback", v, 1);

        // vector table: R4 R5 R6 R1 R8
        for (int i = 0; i < NV; i++) begin
            start(8'h08 | 8'(i));
            rd(2'd0, v);
            chk(v[3] == 1, "R1 start bit while running", v[3], 1);
            chk(int'(ch_sel) == i, "R4 mux select", int'(ch_sel), i);
            wait_eoc(dt);
            chk(dt == 20, "R6 duration at prescaler 1", dt, 20);
            rd(2'd0, v);
            chk(v[3] == 0, "R1 start bit self-clear", v[3], 0);
            chk(v[2:0] == i, "R4 channel field readback", v[2:0], i);
            rd(2'd2, v);
            chk(v == (V_EXP[i] >> 2), "R5 result high bits", v, V_EXP[i] >> 2);
            rd(2'd3, v);
            chk(v == (V_EXP[i] & 3), "R8 result low bits", v, V_EXP[i] & 3);
        end

        // R7: start while busy is ignored, result atomic, prescaler sampled (R6)
        start(8'h0C);
        repeat (3) @(negedge clk);
        rd(2'd2, v);
        chk(v == 0, "R7 high result unchanged mid-conversion", v, 0);
        rd(2'd3, v);
        chk(v == 1, "R7 low result unchanged mid-conversion", v, 1);
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h09);
        chk(ch_sel == 3'd4, "R4 channel held mid-conversion", int'(ch_sel), 4);
        wait_eoc(dt);
        chk(dt == 20, "R7 duration not extended", dt, 20);
        rd(2'd2, v);
        chk(v == 128, "R7 final result high", v, 128);
        repeat (5) @(negedge clk);
        rd(2'd0, v);
        chk(v[3] == 0, "R7 no second conversion", v[3], 0);

        // R6 at prescaler 3
        start(8'h0D);
        wait_eoc(dt);
        chk(dt == 60, "R6 duration at prescaler 3", dt, 60);
        rd(2'd2, v);
        chk(v == (341 >> 2), "R5 result channel 5", v, 341 >> 2);

        // R2: writing 1 to flag keeps it, writing 0 clears it
        wr(2'd0, 8'h15);
        rd(2'd0, v);
        chk(v[4] == 1, "R2 flag kept on write of 1", v[4], 1);
        wr(2'd0, 8'h05);
        rd(2'd0, v);
        chk(v[4] == 0, "R2 flag cleared on write of 0", v[4], 0);

        // R6 at prescaler 0, with R3 interrupt
        wr(2'd1, 8'd0);
        start(8'h2E);
        chk(irq == 0, "R3 irq low while running", int'(irq), 0);
        wait_eoc(dt);
        chk(dt == 640, "R6 duration at prescaler 0", dt, 640);
        chk(irq == 1, "R3 irq on completion", int'(irq), 1);
        wr(2'd0, 8'h36);
        chk(irq == 1, "R3 irq held while flag set", int'(irq), 1);
        wr(2'd0, 8'h16);
        chk(irq == 0, "R3 irq masked by enable", int'(irq), 0);
        wr(2'd0, 8'h26);
        chk(irq == 0, "R3 irq low after flag clear", int'(irq), 0);
        wr(2'd1, 8'd1);
        start(8'h2F);
        wait_eoc(dt);
        chk(irq == 1, "R3 irq re-armed", int'(irq), 1);
        rd(2'd2, v);
        chk(v == 0, "R5 result channel 7 high", v, 0);
        rd(2'd3, v);
        chk(v == 1, "R5 result channel 7 low", v, 1);

        // R9: reset mid-conversion
        start(8'h2A);
        repeat (4) @(negedge clk);
        rst_n = 0; #1;
        chk(irq == 0, "R9 irq cleared by reset", int'(irq), 0);
        rd(2'd0, v);
        chk(v == 0, "R9 control cleared by reset", v, 0);
        rd(2'd2, v);
        chk(v == 0, "R9 result cleared by reset", v, 0);
        rst_n = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule